// File: doc/BRIEF.md
# Segmented Register Space Address Mapper

This block decodes a 17-bit word address from a simple bus master in the system clock domain. It steers single-cycle write and read strobes to one of several groups of register-mapped cores and returns the selected 32-bit read word through a register. The address space is divided by core type into segments: one for hash cores, one for random number generators and one for ciphers. Each segment has its own core selector.

Core 0 of the hash segment is not a processing core. It is a built-in bank of board-level registers: a board identifier, a bitstream version and one scratch word. The generator and cipher segments each hold a placeholder bank at core 0, made of a fixed identifier and a scratch word. External hash cores answer combinationally, and the mapper registers the selected word so that it is valid one clock after the read strobe. A hash slot or a placeholder bank can be left out at elaboration time. Anything that is not mapped drops writes and reads back as zero, and no error is reported.

Top module: `seg_map_top`

## Requirements
- R1: The word address splits as segment = bits [16:14], core = bits [13:8], register = bits [7:0]. Segment 0 is hash, 1 is random generator, 2 is cipher, and 3 to 7 are unmapped.
- R2: Hash segment core 0 is the global bank. Register 0 reads BOARD_TYPE and register 1 reads VERSION; both are read-only and writes to them are dropped. Register 2 is a read/write scratch word.
- R3: A write or read strobe to hash core k (1 ≤ k ≤ NUM_HASH) drives hash_wr/hash_rd bit k-1 high in the same cycle, with hash_reg = address bits [7:0] and hash_wdata = bus_wdata. Every other slot strobe stays low.
- R4: bus_rdata loads the selected word at the clock edge that samples bus_rd, and holds its value on cycles without bus_rd.
- R5: Reads of unmapped space return zero and writes to it change nothing. Unmapped space covers segments 3 to 7, core indices above the last implemented one, and bank register offsets without a register.
- R6: A hash slot whose bit in HASH_EN is 0 never sees a strobe and reads as zero, whatever its core returns.
- R7: Core 0 of the generator segment and core 0 of the cipher segment are placeholder banks. Register 0 returns RNG_ID or CIPHER_ID read-only, and register 1 is a read/write scratch word.
- R8: Synchronous active-high reset clears every scratch word and bus_rdata to zero.
- R9: A read and a write to the same register in one cycle return the value held before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 17 | Word address from the master |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hash_wr | output | NUM_HASH | Per-slot write strobe to hash cores |
| hash_rd | output | NUM_HASH | Per-slot read strobe to hash cores |
| hash_reg | output | 8 | Register offset to hash cores |
| hash_wdata | output | 32 | Write data to hash cores |
| hash_rdata | input | NUM_HASH*32 | Combinational read data from hash cores, slot 0 in the low word |

## Verification
Read capture and a write to the same scratch word can fall in one cycle, because a read takes the combinational bank output while the write commits at the same edge. The bench loads a known scratch value, then raises both strobes together on that address with a new value. It expects the old value on bus_rdata after the edge and the new value on a following read. Strobe routing is judged mid-cycle at the slot outputs, and the registered read path is judged after the capturing edge.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
   localparam int ADDR_W = 17;
   localparam int SEG_W  = 3;
   localparam int CORE_W = 6;
   localparam int REG_W  = 8;
   localparam int DATA_W = 32;

   typedef enum logic [SEG_W-1:0] {
      SEG_HASH   = 3'd0,
      SEG_RNG    = 3'd1,
      SEG_CIPHER = 3'd2
   } seg_e;

   typedef struct packed {
      logic [SEG_W-1:0]  seg;
      logic [CORE_W-1:0] core;
      logic [REG_W-1:0]  regs;
   } word_addr_t;
endpackage

// File: rtl/seg_map_bank.sv
module seg_map_bank
   import seg_map_pkg::*;
#(
   parameter int                      NUM_RO  = 2,
   parameter logic [NUM_RO*DATA_W-1:0] RO_VALS = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [REG_W-1:0]  reg_off,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [REG_W-1:0] SCRATCH_IDX = REG_W'(NUM_RO);

   logic [DATA_W-1:0] scratch_q;

   always_ff @(posedge clk) begin
      if (rst)
         scratch_q <= '0;
      else if (wr && reg_off == SCRATCH_IDX)
         scratch_q <= wdata;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_RO; i++)
         if (reg_off == REG_W'(i))
            rdata = RO_VALS[i*DATA_W +: DATA_W];
      if (reg_off == SCRATCH_IDX)
         rdata = scratch_q;
   end
endmodule

// File: rtl/seg_map_hash_sel.sv
module seg_map_hash_sel
   import seg_map_pkg::*;
#(
   parameter int                  NUM_HASH = 3,
   parameter logic [NUM_HASH-1:0] HASH_EN  = '1
) (
   input  logic                       seg_hit,
   input  logic [CORE_W-1:0]          core,
   input  logic                       wr,
   input  logic                       rd,
   input  logic [NUM_HASH*DATA_W-1:0] slot_rdata,
   output logic [NUM_HASH-1:0]        slot_wr,
   output logic [NUM_HASH-1:0]        slot_rd,
   output logic                       glob_hit,
   output logic [DATA_W-1:0]          rdata
);
   logic [NUM_HASH-1:0] slot_hit;

   assign glob_hit = seg_hit && (core == '0);

   for (genvar i = 0; i < NUM_HASH; i++) begin : g_slot
      if (HASH_EN[i]) begin : g_on
         assign slot_hit[i] = seg_hit && (core == CORE_W'(i + 1));
      end else begin : g_off
         assign slot_hit[i] = 1'b0;
      end
      assign slot_wr[i] = slot_hit[i] && wr;
      assign slot_rd[i] = slot_hit[i] && rd;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_HASH; i++)
         rdata = rdata | ({DATA_W{slot_hit[i]}} & slot_rdata[i*DATA_W +: DATA_W]);
   end
endmodule

// File: rtl/seg_map_top.sv
module seg_map_top
   import seg_map_pkg::*;
#(
   parameter int                  NUM_HASH   = 3,
   parameter logic [NUM_HASH-1:0] HASH_EN    = 3'b101,
   parameter bit                  RNG_EN     = 1'b1,
   parameter bit                  CIPHER_EN  = 1'b1,
   parameter logic [DATA_W-1:0]   BOARD_TYPE = 32'h0000_B0A7,
   parameter logic [DATA_W-1:0]   VERSION    = 32'h0001_0203,
   parameter logic [DATA_W-1:0]   RNG_ID     = 32'hA5A5_0001,
   parameter logic [DATA_W-1:0]   CIPHER_ID  = 32'hC1C1_0002
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [NUM_HASH-1:0]        hash_wr,
   output logic [NUM_HASH-1:0]        hash_rd,
   output logic [REG_W-1:0]           hash_reg,
   output logic [DATA_W-1:0]          hash_wdata,
   input  logic [NUM_HASH*DATA_W-1:0] hash_rdata
);
   if (SEG_W + CORE_W + REG_W != ADDR_W) begin : g_bad_split
      $error("address fields do not add up to the word address width");
   end
   if (NUM_HASH < 1 || NUM_HASH > (1 << CORE_W) - 1) begin : g_bad_count
      $error("NUM_HASH must fit in the core field beside the global bank");
   end

   word_addr_t        a;
   logic              hit_hash, rng_hit, cip_hit, glob_hit;
   logic [DATA_W-1:0] glob_rd, rng_rd, cip_rd, slots_rd, next_rd;

   assign a        = word_addr_t'(bus_addr);
   assign hit_hash = (a.seg == SEG_HASH);
   assign rng_hit  = RNG_EN    && (a.seg == SEG_RNG)    && (a.core == '0);
   assign cip_hit  = CIPHER_EN && (a.seg == SEG_CIPHER) && (a.core == '0);

   seg_map_hash_sel #(.NUM_HASH(NUM_HASH), .HASH_EN(HASH_EN)) u_hash (
      .seg_hit   (hit_hash),
      .core      (a.core),
      .wr        (bus_wr),
      .rd        (bus_rd),
      .slot_rdata(hash_rdata),
      .slot_wr   (hash_wr),
      .slot_rd   (hash_rd),
      .glob_hit  (glob_hit),
      .rdata     (slots_rd)
   );

   seg_map_bank #(.NUM_RO(2), .RO_VALS({VERSION, BOARD_TYPE})) u_glob (
      .clk(clk), .rst(rst), .wr(bus_wr && glob_hit), .reg_off(a.regs),
      .wdata(bus_wdata), .rdata(glob_rd)
   );

   seg_map_bank #(.NUM_RO(1), .RO_VALS(RNG_ID)) u_rng (
      .clk(clk), .rst(rst), .wr(bus_wr && rng_hit), .reg_off(a.regs),
      .wdata(bus_wdata), .rdata(rng_rd)
   );

   seg_map_bank #(.NUM_RO(1), .RO_VALS(CIPHER_ID)) u_cip (
      .clk(clk), .rst(rst), .wr(bus_wr && cip_hit), .reg_off(a.regs),
      .wdata(bus_wdata), .rdata(cip_rd)
   );

   assign next_rd = slots_rd
                  | ({DATA_W{glob_hit}} & glob_rd)
                  | ({DATA_W{rng_hit}}  & rng_rd)
                  | ({DATA_W{cip_hit}}  & cip_rd);

   always_ff @(posedge clk) begin
      if (rst)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= next_rd;
   end

   assign hash_reg   = a.regs;
   assign hash_wdata = bus_wdata;
endmodule

// File: rtl/seg_map_chk.sv
module seg_map_chk
   import seg_map_pkg::*;
#(
   parameter int                  NUM_HASH   = 3,
   parameter logic [NUM_HASH-1:0] HASH_EN    = '1,
   parameter logic [DATA_W-1:0]   BOARD_TYPE = '0
) (
   input logic                clk,
   input logic                rst,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_HASH-1:0] hash_wr,
   input logic [NUM_HASH-1:0] hash_rd
);
   AST_BOARD_WORD: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == '0) |=> bus_rdata == BOARD_TYPE);  // R2
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr[16:14] > 3'd2) |=> bus_rdata == '0);  // R5
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata));  // R4
   AST_ONE_WR_SLOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hash_wr) && $onehot0(hash_rd));  // R3
   AST_OFF_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
      ((hash_wr | hash_rd) & ~HASH_EN) == '0);  // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> bus_rdata == '0);  // R8

   for (genvar i = 0; i < NUM_HASH; i++) begin : g_route
      AST_SLOT_ROUTE: assert property (@(posedge clk) disable iff (rst)
         (hash_wr[i] || hash_rd[i]) |->
            (bus_addr[16:14] == 3'd0 && bus_addr[13:8] == CORE_W'(i + 1)
             && (bus_wr || bus_rd)));  // R3
   end
endmodule

bind seg_map_top seg_map_chk #(
   .NUM_HASH(NUM_HASH), .HASH_EN(HASH_EN), .BOARD_TYPE(BOARD_TYPE)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .hash_wr(hash_wr), .hash_rd(hash_rd)
);

// File: tb/test_seg_map_top.sv
`timescale 1ns/100ps
module test_seg_map_top;
   localparam int NH = 3;
   localparam logic [31:0] BOARD = 32'h0000_B0A7, VER = 32'h0001_0203;
   localparam logic [31:0] RID = 32'hA5A5_0001, CID = 32'hC1C1_0002;

   logic          clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [16:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata, hash_wdata;
   logic [NH-1:0] hash_wr, hash_rd;
   logic [7:0]    hash_reg;
   logic [NH*32-1:0] hash_rdata;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_map_top i_seg_map_top (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hash_wr(hash_wr),
      .hash_rd(hash_rd), .hash_reg(hash_reg), .hash_wdata(hash_wdata),
      .hash_rdata(hash_rdata)
   );

   // Hash core models: four words each, preset to a nonzero pattern.
   logic [31:0] cmem [NH][4];
   always @(posedge clk) begin
      for (int i = 0; i < NH; i++)
         for (int j = 0; j < 4; j++)
            if (rst) cmem[i][j] <= 32'hEE00_0000 | (i << 8) | j;
            else if (hash_wr[i] && hash_reg == 8'(j)) cmem[i][j] <= hash_wdata;
   end
   always_comb
      for (int i = 0; i < NH; i++)
         hash_rdata[i*32 +: 32] = (hash_reg < 8'd4) ? cmem[i][hash_reg[1:0]] : 32'h0;

   typedef struct packed {
      logic        is_rd;
      logic [16:0] addr;
      logic [31:0] data;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 17'h00000, BOARD,         4'd2},  // R2 board word
      '{1'b1, 17'h00001, VER,           4'd2},  // R2 version word
      '{1'b0, 17'h00002, 32'hDEADBEEF,  4'd2},
      '{1'b1, 17'h00002, 32'hDEADBEEF,  4'd2},  // R2 scratch
      '{1'b0, 17'h00000, 32'h12345678,  4'd2},
      '{1'b1, 17'h00000, BOARD,         4'd2},  // R2 read-only kept
      '{1'b0, 17'h00101, 32'h11110001,  4'd3},
      '{1'b1, 17'h00101, 32'h11110001,  4'd3},  // R3 core 1 reg 1
      '{1'b0, 17'h00303, 32'h33330003,  4'd3},
      '{1'b1, 17'h00303, 32'h33330003,  4'd3},  // R3 core 3 reg 3
      '{1'b1, 17'h00102, 32'hEE000002,  4'd1},  // R1 register field
      '{1'b0, 17'h00202, 32'h22220002,  4'd6},
      '{1'b1, 17'h00202, 32'h00000000,  4'd6},  // R6 disabled slot
      '{1'b1, 17'h04000, RID,           4'd7},  // R7 generator id
      '{1'b0, 17'h04001, 32'h0BADF00D,  4'd7},
      '{1'b1, 17'h04001, 32'h0BADF00D,  4'd7},  // R7 generator scratch
      '{1'b1, 17'h08000, CID,           4'd7},  // R7 cipher id
      '{1'b0, 17'h08001, 32'hCAFE0001,  4'd7},
      '{1'b1, 17'h08001, 32'hCAFE0001,  4'd7},  // R7 cipher scratch
      '{1'b1, 17'h04001, 32'h0BADF00D,  4'd1},  // R1 segments kept apart
      '{1'b0, 17'h14001, 32'hFFFFFFFF,  4'd5},
      '{1'b1, 17'h14001, 32'h00000000,  4'd5},  // R5 segment 5
      '{1'b1, 17'h00400, 32'h00000000,  4'd5}   // R5 core beyond range
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input int req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_op(input logic wr, input logic rd,
                         input logic [16:0] addr, input logic [31:0] d);
      @(negedge clk);
      bus_addr = addr; bus_wdata = d; bus_wr = wr; bus_rd = rd;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(bus_rdata, 32'h0, 8, "R8 rdata at reset");
      rst = 1'b0;
      chk({29'h0, hash_wr}, 32'h0, 3, "R3 no strobe idle");

      for (int v = 0; v < NV; v++) begin
         bus_op(!VECS[v].is_rd, VECS[v].is_rd, VECS[v].addr, VECS[v].data);
         if (VECS[v].is_rd)
            chk(bus_rdata, VECS[v].data, int'(VECS[v].req), $sformatf("vector %0d", v));
      end

      // R3 routing seen mid-cycle at the slot outputs
      @(negedge clk);
      bus_addr = 17'h00305; bus_wdata = 32'h5555AAAA; bus_wr = 1'b1;
      #1;
      chk({29'h0, hash_wr}, 32'h4, 3, "R3 write strobe slot 2");
      chk({24'h0, hash_reg}, 32'h5, 3, "R3 register offset");
      chk(hash_wdata, 32'h5555AAAA, 3, "R3 write data");
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 17'h00100;
      #1;
      chk({29'h0, hash_rd}, 32'h1, 3, "R3 read strobe slot 0");
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 17'h00200;
      #1;
      chk({29'h0, hash_wr | hash_rd}, 32'h0, 6, "R6 disabled slot strobes");
      bus_wr = 1'b0;

      // R4: no change before the capturing edge, hold when idle
      bus_op(1'b0, 1'b1, 17'h00001, 32'h0);
      @(negedge clk);
      bus_addr = 17'h00000; bus_rd = 1'b1;
      #1;
      chk(bus_rdata, VER, 4, "R4 before edge");
      @(negedge clk);
      bus_rd = 1'b0;
      chk(bus_rdata, BOARD, 4, "R4 after edge");
      bus_addr = 17'h04000;
      repeat (3) @(negedge clk);
      chk(bus_rdata, BOARD, 4, "R4 hold when idle");

      // R5: unused bank offset reads zero and a write there leaves scratch alone
      bus_op(1'b0, 1'b1, 17'h00003, 32'h0);
      chk(bus_rdata, 32'h0, 5, "R5 empty bank offset");
      bus_op(1'b1, 1'b0, 17'h00003, 32'h77777777);
      bus_op(1'b0, 1'b1, 17'h00002, 32'h0);
      chk(bus_rdata, 32'hDEADBEEF, 5, "R5 scratch untouched");

      // R9: same-cycle read and write to the scratch word
      bus_op(1'b1, 1'b1, 17'h00002, 32'h0F0F0F0F);
      chk(bus_rdata, 32'hDEADBEEF, 9, "R9 old value on collision");
      bus_op(1'b0, 1'b1, 17'h00002, 32'h0);
      chk(bus_rdata, 32'h0F0F0F0F, 9, "R9 write landed");

      // R8: reset clears scratch words
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(bus_rdata, 32'h0, 8, "R8 rdata after reset");
      bus_op(1'b0, 1'b1, 17'h00002, 32'h0);
      chk(bus_rdata, 32'h0, 8, "R8 global scratch cleared");
      bus_op(1'b0, 1'b1, 17'h04001, 32'h0);
      chk(bus_rdata, 32'h0, 8, "R8 generator scratch cleared");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule